// File: doc/BRIEF.md
# Link Receive Alignment Stage

This block sits behind the deserialisers of a group of trigger input links and lines their parallel words up against the local 40 MHz processing clock before any downstream logic combines them. Each link gets two adjustments. One is a choice of which clock edge latches its incoming word, to absorb the phase offset between the link and the local clock. The other is a delay line in whole clock periods, to make up for cables of different length. Once both are set correctly, every link presents the word from the same bunch crossing in the same cycle.

Settings are written one link at a time through a small configuration port. Any write to a link empties that link's pipeline, so no word from before the change reaches the output. A per-link mismatch counter compares each valid aligned word against a reference word supplied on a port. Test patterns can then confirm that the settings line the links up. A wrong setting shows as a growing count on the affected link.

Top module: `link_align`

## Requirements
- R1: While reset is asserted, and for the two rising edges after it is released (a two-stage synchroniser), every `out_valid` bit, every `out_data` bit and every error count is zero. After reset every link uses rising-edge capture and a delay of 0.
- R2: With edge select 0 (rising) and delay D, the word and valid present at rising edge k appear on the link's outputs right after rising edge k+D and stay there until the next rising edge.
- R3: With edge select 1 (falling) and delay D, the word and valid latched on the falling edge just before rising edge k appear on the link's outputs right after rising edge k+D. The output is always driven from rising-edge registers.
- R4: The delay of each link is any whole number of clock periods from 0 to 2^DLY_W-1 (0 to 15 by default), set per link. When the delays and edges match the cable skews, all links show the same crossing together.
- R5: A configuration write (`cfg_we`=1 at a rising edge) loads `cfg_edge_fall` and `cfg_delay` into link `cfg_link` only. The other links keep their settings and their data flow without a break.
- R6: A configuration write to a link discards every word that link latched at or before the write edge. Its outputs read valid 0 and data 0 until the first word latched after the write has passed through the new delay.
- R7: A word that arrives with its valid at 0 comes out with valid 0 and data 0.
- R8: When `chk_en` is 1 at a rising edge, a link whose output at that moment is valid and differs from `chk_ref` increments its error count by one. Invalid words are ignored, and when `chk_en` is 0 the counts do not change.
- R9: An error count that has reached 2^CNT_W-1 holds that value.
- R10: `chk_clr`=1 at a rising edge zeroes every error count, and takes priority over counting.
- R11: Link i uses bits [i*LINK_W +: LINK_W] of `in_data` and `out_data`, bit i of `in_valid` and `out_valid`, and bits [i*CNT_W +: CNT_W] of `err_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local processing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| in_data | input | NLINK*LINK_W | Deserialised words, one per link |
| in_valid | input | NLINK | Per-link word valid |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_link | input | SEL_W | Link addressed by the write |
| cfg_edge_fall | input | 1 | Capture edge to load: 0 rising, 1 falling |
| cfg_delay | input | DLY_W | Delay in whole clocks to load |
| chk_en | input | 1 | Enable mismatch counting |
| chk_clr | input | 1 | Clear all mismatch counts |
| chk_ref | input | LINK_W | Reference word compared against each valid output |
| out_data | output | NLINK*LINK_W | Aligned words |
| out_valid | output | NLINK | Aligned word valid |
| err_cnt | output | NLINK*CNT_W | Saturating mismatch count per link |

## Verification
The hardest case to reach is a falling-edge link whose word differs from the one a rising-edge latch would take. To reach it, the bench changes the input words 70 % of the way through each period, after the falling edge. The two edge choices then latch words one crossing apart, so a mistaken edge shows as a one-word slip. The bench also feeds each link a stream skewed by a different cable length and picks delays that cancel the skew. It then moves one link off alignment, so the mismatch counters are driven both to zero and to saturation by real misalignment, not by forced values.

// File: rtl/link_align_pkg.sv
package link_align_pkg;
  typedef enum logic {
    CAP_RISE = 1'b0,
    CAP_FALL = 1'b1
  } cap_edge_e;
endpackage

// File: rtl/link_align_capture.sv
module link_align_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_fall,
  input  logic         flush,
  input  logic [W-1:0] din,
  input  logic         vin,
  output logic [W-1:0] cap_d,
  output logic         cap_v
);
  logic [W-1:0] neg_d;
  logic         neg_v;
  logic [W-1:0] sel_d, cap_d_nxt;
  logic         sel_v, cap_v_nxt;

  // latch on the falling edge; used only when that edge is selected
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_d <= '0;
      neg_v <= 1'b0;
    end else begin
      neg_d <= din;
      neg_v <= vin;
    end
  end

  always_comb begin
    sel_d = edge_fall ? neg_d : din;
    sel_v = edge_fall ? neg_v : vin;
    cap_v_nxt = sel_v && !flush;
    cap_d_nxt = cap_v_nxt ? sel_d : '0;
  end

  // rising-edge capture register: all later logic is in this domain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_d <= '0;
      cap_v <= 1'b0;
    end else begin
      cap_d <= cap_d_nxt;
      cap_v <= cap_v_nxt;
    end
  end
endmodule

// File: rtl/link_align_delay.sv
module link_align_delay #(
  parameter int W     = 16,
  parameter int DLY_W = 4,
  localparam int DEPTH = 2 ** DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [DLY_W-1:0] sel,
  input  logic [W-1:0]     in_d,
  input  logic             in_v,
  output logic [W-1:0]     out_d,
  output logic             out_v
);
  logic [W-1:0] st_d     [DEPTH-1];
  logic         st_v     [DEPTH-1];
  logic [W-1:0] st_d_nxt [DEPTH-1];
  logic         st_v_nxt [DEPTH-1];
  logic [W-1:0] tap_d    [DEPTH];
  logic         tap_v    [DEPTH];

  always_comb begin
    st_d_nxt[0] = flush ? '0 : in_d;
    st_v_nxt[0] = flush ? 1'b0 : in_v;
    for (int k = 1; k < DEPTH - 1; k++) begin
      st_d_nxt[k] = flush ? '0 : st_d[k-1];
      st_v_nxt[k] = flush ? 1'b0 : st_v[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        st_d[k] <= '0;
        st_v[k] <= 1'b0;
      end
    end else begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        st_d[k] <= st_d_nxt[k];
        st_v[k] <= st_v_nxt[k];
      end
    end
  end

  // tap 0 is the capture register itself, tap k is k clocks later
  always_comb begin
    tap_d[0] = in_d;
    tap_v[0] = in_v;
    for (int k = 1; k < DEPTH; k++) begin
      tap_d[k] = st_d[k-1];
      tap_v[k] = st_v[k-1];
    end
    out_d = tap_d[sel];
    out_v = tap_v[sel];
  end
endmodule

// File: rtl/link_align_errcnt.sv
module link_align_errcnt #(
  parameter int W  = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic [W-1:0]  ref_word,
  input  logic [W-1:0]  d,
  input  logic          v,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [CW-1:0] cnt_nxt;
  logic          bump;

  always_comb begin
    bump = en && v && (d != ref_word) && (cnt != CNT_MAX);
    if (clr)       cnt_nxt = '0;
    else if (bump) cnt_nxt = cnt + 1'b1;
    else           cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/link_align.sv
module link_align
  import link_align_pkg::*;
#(
  parameter int NLINK  = 4,
  parameter int LINK_W = 16,
  parameter int DLY_W  = 4,
  parameter int CNT_W  = 8,
  localparam int SEL_W = (NLINK > 1) ? $clog2(NLINK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NLINK*LINK_W-1:0] in_data,
  input  logic [NLINK-1:0]        in_valid,
  input  logic                    cfg_we,
  input  logic [SEL_W-1:0]        cfg_link,
  input  logic                    cfg_edge_fall,
  input  logic [DLY_W-1:0]        cfg_delay,
  input  logic                    chk_en,
  input  logic                    chk_clr,
  input  logic [LINK_W-1:0]       chk_ref,
  output logic [NLINK*LINK_W-1:0] out_data,
  output logic [NLINK-1:0]        out_valid,
  output logic [NLINK*CNT_W-1:0]  err_cnt
);
  logic rs_a, rs_b;
  logic rst_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  assign rst_q = rs_b;

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    cap_edge_e        edge_q, edge_nxt;
    logic [DLY_W-1:0] dly_q, dly_nxt;
    logic             wr_hit;
    logic [LINK_W-1:0] cap_d, al_d;
    logic             cap_v, al_v;

    assign wr_hit = cfg_we && (cfg_link == SEL_W'(i));

    always_comb begin
      edge_nxt = cfg_edge_fall ? CAP_FALL : CAP_RISE;
      dly_nxt  = cfg_delay;
    end

    always_ff @(posedge clk or negedge rst_q) begin
      if (!rst_q) begin
        edge_q <= CAP_RISE;
        dly_q  <= '0;
      end else if (wr_hit) begin
        edge_q <= edge_nxt;
        dly_q  <= dly_nxt;
      end
    end

    link_align_capture #(.W(LINK_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_q),
      .edge_fall (edge_q == CAP_FALL),
      .flush     (wr_hit),
      .din       (in_data[i*LINK_W +: LINK_W]),
      .vin       (in_valid[i]),
      .cap_d     (cap_d),
      .cap_v     (cap_v)
    );

    link_align_delay #(.W(LINK_W), .DLY_W(DLY_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_q),
      .flush (wr_hit),
      .sel   (dly_q),
      .in_d  (cap_d),
      .in_v  (cap_v),
      .out_d (al_d),
      .out_v (al_v)
    );

    link_align_errcnt #(.W(LINK_W), .CW(CNT_W)) u_err (
      .clk      (clk),
      .rst_n    (rst_q),
      .en       (chk_en),
      .clr      (chk_clr),
      .ref_word (chk_ref),
      .d        (al_d),
      .v        (al_v),
      .cnt      (err_cnt[i*CNT_W +: CNT_W])
    );

    assign out_data[i*LINK_W +: LINK_W] = al_d;
    assign out_valid[i]                 = al_v;
  end
endmodule

// File: rtl/link_align_chk.sv
module link_align_chk #(
  parameter int NLINK  = 4,
  parameter int LINK_W = 16,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [SEL_W-1:0]        cfg_link,
  input logic                    chk_en,
  input logic                    chk_clr,
  input logic [NLINK*LINK_W-1:0] out_data,
  input logic [NLINK-1:0]        out_valid,
  input logic [NLINK*CNT_W-1:0]  err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar i = 0; i < NLINK; i++) begin : g_a
    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_link == SEL_W'(i)) |=> !out_valid[i]);
    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[i] |-> (out_data[i*LINK_W +: LINK_W] == '0));
    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_clr |=> (err_cnt[i*CNT_W +: CNT_W] == '0));
    // R8
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_clr |=> (err_cnt[i*CNT_W +: CNT_W] == $past(err_cnt[i*CNT_W +: CNT_W]) ||
                    err_cnt[i*CNT_W +: CNT_W] == $past(err_cnt[i*CNT_W +: CNT_W]) + 1'b1));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_en && !chk_clr) |=> $stable(err_cnt[i*CNT_W +: CNT_W]));
    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_cnt[i*CNT_W +: CNT_W] == CNT_MAX && !chk_clr) |=>
        (err_cnt[i*CNT_W +: CNT_W] == CNT_MAX));
  end
endmodule

bind link_align link_align_chk #(
  .NLINK(NLINK), .LINK_W(LINK_W), .CNT_W(CNT_W), .SEL_W(SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_link  (cfg_link),
  .chk_en    (chk_en),
  .chk_clr   (chk_clr),
  .out_data  (out_data),
  .out_valid (out_valid),
  .err_cnt   (err_cnt)
);

// File: tb/link_align_bench.sv
module link_align_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CHK_OFS    = CLK_PERIOD / 5;
  localparam int DRV_OFS    = (CLK_PERIOD * 7) / 10;
  localparam int NL   = 4;
  localparam int W    = 16;
  localparam int DW   = 4;
  localparam int CW   = 8;
  localparam int LW   = 2;
  localparam int MAXC = 2048;
  localparam int CMAX = 255;

  logic            clk, rst_n;
  logic [NL*W-1:0] in_data;
  logic [NL-1:0]   in_valid;
  logic            cfg_we;
  logic [LW-1:0]   cfg_link;
  logic            cfg_edge_fall;
  logic [DW-1:0]   cfg_delay;
  logic            chk_en, chk_clr;
  logic [W-1:0]    chk_ref;
  logic [NL*W-1:0] out_data;
  logic [NL-1:0]   out_valid;
  logic [NL*CW-1:0] err_cnt;

  link_align #(.NLINK(NL), .LINK_W(W), .DLY_W(DW), .CNT_W(CW)) u_link_align (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .cfg_we(cfg_we), .cfg_link(cfg_link), .cfg_edge_fall(cfg_edge_fall),
    .cfg_delay(cfg_delay), .chk_en(chk_en), .chk_clr(chk_clr), .chk_ref(chk_ref),
    .out_data(out_data), .out_valid(out_valid), .err_cnt(err_cnt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  int n_chk = 0, n_fail = 0, cyc = 0, rel_cyc = 1000000;
  bit done = 0;
  logic [W-1:0] hd [NL][MAXC];
  logic         hv [NL][MAXC];
  int  flush_c [NL];
  int  dly_m   [NL];
  bit  fall_m  [NL];
  int  ecnt    [NL];
  logic [W-1:0] pd [NL];
  logic         pv [NL];
  int  skew    [NL] = '{0, 1, 3, 12};
  bit  gaps = 0, en_g = 0, clr_g = 0, refconst = 0;
  bit  en_d = 0, clr_d = 0, we_d = 0, wf_d = 0;
  int  wl_d = 0, wd_d = 0;
  logic [W-1:0] ref_d = '0;

  function automatic logic [W-1:0] pat(int n);
    logic [31:0] x;
    x = n * 32'd40503 + 32'd12345;
    return x[15:0] ^ x[27:12];
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic drive_inputs(bit we, int lk, bit fl, int dl);
    for (int i = 0; i < NL; i++) begin
      hd[i][cyc] = pat(cyc - skew[i]);
      hv[i][cyc] = !(gaps && i == 2 && (cyc % 7) == 3);
      in_data[i*W +: W] = hd[i][cyc];
      in_valid[i]       = hv[i][cyc];
    end
    cfg_we = we; cfg_link = LW'(lk); cfg_edge_fall = fl; cfg_delay = DW'(dl);
    we_d = we; wl_d = lk; wf_d = fl; wd_d = dl;
    chk_en = en_g; chk_clr = clr_g;
    chk_ref = refconst ? 16'hFFFF : pd[0];
    en_d = en_g; clr_d = clr_g; ref_d = chk_ref;
  endtask

  task automatic step(bit we = 0, int lk = 0, bit fl = 0, int dl = 0);
    bit cl;
    @(posedge clk);
    cyc++;
    cl = clr_d;
    // counter model at this edge (uses outputs of the previous cycle)
    for (int i = 0; i < NL; i++) begin
      if (clr_d) ecnt[i] = 0;
      else if (en_d && pv[i] && pd[i] !== ref_d && ecnt[i] < CMAX) ecnt[i]++;
    end
    if (we_d) begin
      dly_m[wl_d] = wd_d; fall_m[wl_d] = wf_d; flush_c[wl_d] = cyc;
    end
    #(CHK_OFS);
    for (int i = 0; i < NL; i++) begin
      int src, idx;
      logic [W-1:0] ed;
      logic ev;
      string tag;
      src = cyc - dly_m[i];
      if (src <= flush_c[i]) begin
        ed = '0; ev = 1'b0;
        tag = (cyc <= rel_cyc + 2) ? "R1" : "R6";
      end else begin
        idx = fall_m[i] ? src - 2 : src - 1;
        if (idx < 0) idx = 0;
        ev = hv[i][idx];
        ed = ev ? hd[i][idx] : '0;
        tag = !ev ? "R7" : (fall_m[i] ? "R3/R4" : "R2/R4");
      end
      check(out_valid[i] === ev && out_data[i*W +: W] === ed, tag,
            $sformatf("link%0d {valid,data}", i),
            {out_valid[i], out_data[i*W +: W]}, {ev, ed});
      pd[i] = ed; pv[i] = ev;
      begin
        string ctag;
        ctag = (cyc <= rel_cyc + 2) ? "R1" : cl ? "R10" : (ecnt[i] == CMAX) ? "R9" : "R8";
        check(err_cnt[i*CW +: CW] === CW'(ecnt[i]), ctag,
              $sformatf("link%0d err_cnt", i), err_cnt[i*CW +: CW], ecnt[i]);
      end
    end
    #(DRV_OFS - CHK_OFS);
    drive_inputs(we, lk, fl, dl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      flush_c[i] = 1000000; dly_m[i] = 0; fall_m[i] = 0; ecnt[i] = 0;
      pd[i] = '0; pv[i] = 1'b0;
    end
    rst_n = 1'b0;
    drive_inputs(0, 0, 0, 0);
    // R1: reset state
    repeat (4) step();
    rst_n = 1'b1;
    rel_cyc = cyc;
    for (int i = 0; i < NL; i++) flush_c[i] = cyc + 2;
    repeat (4) step();
    // aligned settings: every link shows crossing c-14 in cycle c (R4)
    step(1, 0, 0, 13);
    step(1, 1, 1, 11);
    step(1, 2, 0, 10);
    step(1, 3, 1, 0);
    repeat (20) step();
    en_g = 1;
    repeat (40) step();
    for (int i = 0; i < NL; i++)
      check(err_cnt[i*CW +: CW] === '0, "R4", $sformatf("link%0d aligned count", i),
            err_cnt[i*CW +: CW], 0);
    // R11: link 3 and link 0 slices carry the same crossing
    check(out_valid[3] && out_data[3*W +: W] === out_data[0 +: W], "R11",
          "link3 slice vs link0 slice", out_data[3*W +: W], out_data[0 +: W]);
    // misalign link 2, R5: link 1 keeps flowing
    step(1, 2, 0, 9);
    step();
    check(out_valid[1] === 1'b1 && out_data[W +: W] === pd[1], "R5",
          "link1 unaffected by write to link2", out_data[W +: W], pd[1]);
    repeat (30) step();
    // R7: gaps on link 2
    gaps = 1;
    repeat (40) step();
    gaps = 0;
    // link 1 moved to rising capture, still aligned (R2)
    step(1, 1, 0, 12);
    repeat (30) step();
    // R4 sweep link 0 delay with counting off (R8 ignore)
    en_g = 0;
    for (int d = 0; d < 16; d++) begin
      step(1, 0, d[0], d);
      repeat (19) step();
    end
    // R9 saturation against a constant reference
    clr_g = 1; step(); clr_g = 0;
    refconst = 1; en_g = 1;
    repeat (300) step();
    // R10 clear wins over counting
    clr_g = 1;
    repeat (2) step();
    clr_g = 0;
    repeat (3) step();
    en_g = 0;
    repeat (3) step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule